// File: doc/BRIEF.md
# Tiled Surface Address Generator

The block converts a byte coordinate on a two-dimensional surface into a byte offset within the buffer that holds the surface. The coordinate is a column in bytes (`memX`) and a row (`memY`). The surface is described by its row pitch in bytes and a layout select. The block knows four layouts:

- plain row-major (linear);
- a wide, short tile of 512 bytes by 8 rows;
- a narrow, tall tile of 128 bytes by 32 rows, whose 16-byte units run down the columns;
- a square tile of 64 by 64 bytes, built from nested quadrants, for byte-wide stencil data.

An optional swizzle changes address bit 6 using higher address bits, so that accesses spread across memory channels.

One request is taken on each cycle that `inValid` is high. The offset appears one clock later, with `outValid` high. A flag marks the surface as 8-bit stencil. Stencil data is always stored in the quadrant tile, so a stencil surface that is marked linear still uses that tile. Working out the coordinate from mip level or array slice is left to the caller, and so is the memory access itself.

Top module: `tile_addr_gen`

## Requirements
- R1: With layout code 0 (linear) and `stencil8` low, the offset is memY*pitch + memX, truncated to 32 bits. `swizzleEn` has no effect in this layout.
- R2: With layout code 1 (wide tile, 512 bytes by 8 rows, tiles per row = pitch/512) and swizzle off, the offset is tile*4096 + (memY%8)*512 + memX%512. Here tile = (memY/8)*(pitch/512) + memX/512.
- R3: With layout code 2 (tall tile, 128 bytes by 32 rows, tiles per row = pitch/128) and swizzle off, the offset is tile*4096 + unit*16 + memX%16. Here tile = (memY/32)*(pitch/128) + memX/128, and unit = ((memX%128)/16)*32 + memY%32.
- R4: With layout code 3 (quadrant tile, 64 by 64 bytes, tiles per row = pitch/64) and swizzle off, the offset is tile*4096 + b8*64 + b4*16 + b2*4 + b1. The terms are:
  - tile = (memY/64)*(pitch/64) + memX/64;
  - b8 = ((memX%64)/8)*8 + (memY%64)/8;
  - for k = 4, 2, 1, bk = ((memY/k)%2)*2 + (memX/k)%2.
- R5: In layout code 1 with `swizzleEn` high, offset bit 6 is replaced by bit 6 XOR bit 9 XOR bit 10 of the unswizzled offset. All other bits are unchanged.
- R6: In layout codes 2 and 3 with `swizzleEn` high, offset bit 6 is replaced by bit 6 XOR bit 9 of the unswizzled offset. All other bits are unchanged.
- R7: With `stencil8` high and layout code 0, the offset follows R4 (and R6 when swizzle is on). With layout codes 1 to 3, `stencil8` has no effect.
- R8: `outValid` is high in exactly the cycle after each cycle in which `inValid` was high, and carries that request's offset. When `inValid` is low, `outValid` falls the next cycle and `outOffset` holds its last value.
- R9: After reset, `outValid` is 0 and `outOffset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A request is present this cycle |
| layoutSel | input | 2 | Layout code: 0 linear, 1 wide tile, 2 tall tile, 3 quadrant tile |
| stencil8 | input | 1 | The surface holds 8-bit stencil data |
| swizzleEn | input | 1 | Apply the bit-6 swizzle |
| pitch | input | 32 | Row pitch in bytes, a multiple of the tile width |
| memX | input | 32 | Byte column |
| memY | input | 32 | Row |
| outValid | output | 1 | Offset valid |
| outOffset | output | 32 | Byte offset into the buffer |

## Verification
The bench targets the bit-6 swizzle in each of its two forms, using coordinates that set bit 9 only, and bits 9 and 10 together. A design that chose the wrong XOR term for a layout would get bit 6 wrong, which moves the offset by 64 bytes. It drives a stencil surface marked linear and checks that the quadrant order is used. A design that ignored the stencil flag would return the linear offset, for example 65 instead of 3 at (1,1) with a 64-byte pitch. Random coordinates over every layout, with swizzle on and off, catch mistakes in the unit order within a tile, such as row-major versus column-major, or the y bit placed above or below the x bit. They also catch tile-number errors when the pitch spans many tiles.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  localparam int ADDR_W    = 32;
  localparam int TILE_LOG2 = 12;
  localparam int TILE_W    = ADDR_W - TILE_LOG2;

  typedef enum logic [1:0] {
    LAYOUT_LINEAR = 2'd0,
    LAYOUT_WIDE   = 2'd1,
    LAYOUT_TALL   = 2'd2,
    LAYOUT_QUAD   = 2'd3
  } layout_e;

  typedef enum logic [1:0] {
    SWZ_NONE   = 2'd0,
    SWZ_B9_B10 = 2'd1,
    SWZ_B9     = 2'd2
  } swz_e;

  typedef struct packed {
    logic    load;
    layout_e sel;
    swz_e    swz;
  } ctrlStrobe_t;
endpackage

// File: rtl/tile_addr_ctrl.sv
module tile_addr_ctrl
  import tile_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  layoutSel,
  input  logic        stencil8,
  input  logic        swizzleEn,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  layout_e effLayout;

  // A stencil surface that is marked linear is still stored in quadrant tiles.
  always_comb begin
    effLayout = layout_e'(layoutSel);
    if (effLayout == LAYOUT_LINEAR && stencil8) effLayout = LAYOUT_QUAD;
  end

  always_comb begin
    strobe.load = inValid;
    strobe.sel  = effLayout;
    strobe.swz  = SWZ_NONE;
    if (swizzleEn) begin
      unique case (effLayout)
        LAYOUT_WIDE:             strobe.swz = SWZ_B9_B10;
        LAYOUT_TALL, LAYOUT_QUAD: strobe.swz = SWZ_B9;
        default:                 strobe.swz = SWZ_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/tile_addr_dp.sv
module tile_addr_dp
  import tile_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] pitch,
  input  logic [ADDR_W-1:0] memX,
  input  logic [ADDR_W-1:0] memY,
  output logic [ADDR_W-1:0] outOffset
);
  logic [ADDR_W-1:0] linOff, wideOff, tallOff, quadOff, rawOff, swzOff;
  logic [TILE_W-1:0] wideTile, tallTile, quadTile;

  // Tile numbers, row-major over the surface
  assign wideTile = TILE_W'((memY >> 3) * (pitch >> 9) + (memX >> 9));
  assign tallTile = TILE_W'((memY >> 5) * (pitch >> 7) + (memX >> 7));
  assign quadTile = TILE_W'((memY >> 6) * (pitch >> 6) + (memX >> 6));

  assign linOff  = memY * pitch + memX;
  assign wideOff = {wideTile, memY[2:0], memX[8:0]};
  // 16-byte units run down the column: column index above row index
  assign tallOff = {tallTile, memX[6:4], memY[4:0], memX[3:0]};
  // 8x8 blocks column-major, then nested 2x2 quadrants with y above x
  assign quadOff = {quadTile, memX[5:3], memY[5:3],
                    memY[2], memX[2], memY[1], memX[1], memY[0], memX[0]};

  always_comb begin
    unique case (strobe.sel)
      LAYOUT_WIDE: rawOff = wideOff;
      LAYOUT_TALL: rawOff = tallOff;
      LAYOUT_QUAD: rawOff = quadOff;
      default:     rawOff = linOff;
    endcase
  end

  always_comb begin
    swzOff = rawOff;
    unique case (strobe.swz)
      SWZ_B9_B10: swzOff[6] = rawOff[6] ^ rawOff[9] ^ rawOff[10];
      SWZ_B9:     swzOff[6] = rawOff[6] ^ rawOff[9];
      default:    swzOff[6] = rawOff[6];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outOffset <= '0;
    else if (strobe.load) outOffset <= swzOff;
  end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        layoutSel,
  input  logic              stencil8,
  input  logic              swizzleEn,
  input  logic [ADDR_W-1:0] pitch,
  input  logic [ADDR_W-1:0] memX,
  input  logic [ADDR_W-1:0] memY,
  output logic              outValid,
  output logic [ADDR_W-1:0] outOffset
);
  ctrlStrobe_t strobe;

  tile_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .layoutSel(layoutSel),
    .stencil8(stencil8), .swizzleEn(swizzleEn), .strobe(strobe),
    .outValid(outValid)
  );

  tile_addr_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pitch(pitch),
    .memX(memX), .memY(memY), .outOffset(outOffset)
  );
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk
  import tile_addr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        layoutSel,
  input logic              stencil8,
  input logic [ADDR_W-1:0] pitch,
  input logic [ADDR_W-1:0] memX,
  input logic [ADDR_W-1:0] memY,
  input logic              outValid,
  input logic [ADDR_W-1:0] outOffset
);
  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R8
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R8
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outOffset));
  // R1
  linear_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && layoutSel == 2'd0 && !stencil8) |=>
      outOffset == $past(memY) * $past(pitch) + $past(memX));
  // R2
  wide_lowbits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && layoutSel == 2'd1) |=>
      (outOffset[5:0] == $past(memX[5:0]) && outOffset[8:7] == $past(memX[8:7])));
  // R3
  tall_lowbits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && layoutSel == 2'd2) |=>
      (outOffset[3:0] == $past(memX[3:0]) && outOffset[5:4] == $past(memY[1:0])));
  // R4 R7
  quad_lowbits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (layoutSel == 2'd3 || (layoutSel == 2'd0 && stencil8))) |=>
      (outOffset[0] == $past(memX[0]) && outOffset[1] == $past(memY[0])));
  // R9
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && outOffset == '0));
endmodule

bind tile_addr_gen tile_addr_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .layoutSel(layoutSel),
  .stencil8(stencil8), .pitch(pitch), .memX(memX), .memY(memY),
  .outValid(outValid), .outOffset(outOffset)
);

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  layoutSel = 2'd0;
  logic        stencil8 = 1'b0;
  logic        swizzleEn = 1'b0;
  logic [31:0] pitch = 32'd0, memX = 32'd0, memY = 32'd0;
  logic        outValid;
  logic [31:0] outOffset;

  int unsigned nChecks = 0, nFails = 0;
  int unsigned expQ[$];
  string       tagQ[$];
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tile_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .layoutSel(layoutSel),
    .stencil8(stencil8), .swizzleEn(swizzleEn), .pitch(pitch),
    .memX(memX), .memY(memY), .outValid(outValid), .outOffset(outOffset)
  );

  function automatic int unsigned model(int unsigned lay, bit st, bit sw,
                                        int unsigned p, int unsigned x, int unsigned y);
    int unsigned off, tile, unit, b8, b4, b2, b1, bit6;
    if (lay == 0 && st) lay = 3;
    case (lay)
      1: begin
        tile = (y / 8) * (p / 512) + x / 512;
        off = tile * 4096 + (y % 8) * 512 + x % 512;
        bit6 = ((off >> 6) ^ (off >> 9) ^ (off >> 10)) & 1;
      end
      2: begin
        tile = (y / 32) * (p / 128) + x / 128;
        unit = ((x % 128) / 16) * 32 + y % 32;
        off = tile * 4096 + unit * 16 + x % 16;
        bit6 = ((off >> 6) ^ (off >> 9)) & 1;
      end
      3: begin
        tile = (y / 64) * (p / 64) + x / 64;
        b8 = ((x % 64) / 8) * 8 + (y % 64) / 8;
        b4 = ((y / 4) % 2) * 2 + (x / 4) % 2;
        b2 = ((y / 2) % 2) * 2 + (x / 2) % 2;
        b1 = (y % 2) * 2 + x % 2;
        off = tile * 4096 + b8 * 64 + b4 * 16 + b2 * 4 + b1;
        bit6 = ((off >> 6) ^ (off >> 9)) & 1;
      end
      default: begin
        off = y * p + x;
        bit6 = (off >> 6) & 1;
      end
    endcase
    if (sw) off = (off & ~32'h40) | (bit6 << 6);
    return off;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Driver: present one request per cycle and queue its expected offset
  task automatic drive(string tag, int unsigned lay, bit st, bit sw,
                       int unsigned p, int unsigned x, int unsigned y,
                       bit useFixed = 1'b0, int unsigned fixed = 0);
    @(posedge clk); #1;
    inValid = 1'b1; layoutSel = 2'(lay); stencil8 = st; swizzleEn = sw;
    pitch = p; memX = x; memY = y;
    expQ.push_back(useFixed ? fixed : model(lay, st, sw, p, x, y));
    tagQ.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      inValid = 1'b0;
      memX = $urandom; memY = $urandom; layoutSel = 2'($urandom);
    end
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check("R8 spurious outValid", {31'd0, outValid}, 32'd0);
      end else begin
        string t;
        t = tagQ.pop_front();
        check(t, outOffset, expQ.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset outValid", {31'd0, outValid}, 32'd0);
    check("R9 reset outOffset", outOffset, 32'd0);
    @(posedge clk); #1 rstN = 1'b1;

    // Directed values worked out from the requirements
    drive("R1 linear", 0, 0, 0, 1024, 5, 3, 1, 3077);
    drive("R1 linear swizzle ignored", 0, 0, 1, 512, 0, 1, 1, 512);
    drive("R2 wide row 1", 1, 0, 0, 512, 0, 1, 1, 512);
    drive("R5 wide swizzle bit9", 1, 0, 1, 512, 0, 1, 1, 576);
    drive("R5 wide swizzle bit9+bit10", 1, 0, 1, 512, 0, 3, 1, 1536);
    drive("R3 tall next column", 2, 0, 0, 128, 16, 0, 1, 512);
    drive("R6 tall swizzle", 2, 0, 1, 128, 16, 0, 1, 576);
    drive("R4 quad (1,1)", 3, 0, 0, 64, 1, 1, 1, 3);
    drive("R4 quad y=8", 3, 0, 0, 64, 0, 8, 1, 64);
    drive("R6 quad swizzle x=8", 3, 0, 1, 64, 8, 0, 1, 576);
    drive("R7 stencil linear->quad", 0, 1, 0, 64, 1, 1, 1, 3);
    drive("R7 stencil no effect on wide", 1, 1, 0, 512, 0, 1, 1, 512);
    drive("R4 quad second tile row", 3, 0, 0, 128, 0, 64, 1, 8192);

    // R8: hold while idle
    idle(1);
    @(negedge clk);
    held = outOffset;
    idle(3);
    @(negedge clk);
    check("R8 outValid low when idle", {31'd0, outValid}, 32'd0);
    check("R8 offset held while idle", outOffset, held);

    // Random sweep over every layout, swizzle and stencil flag
    for (int i = 0; i < 4000; i++) begin
      int unsigned lay, p, x, y;
      bit st, sw;
      string t;
      lay = $urandom_range(0, 3);
      st = 1'($urandom);
      sw = 1'($urandom);
      p = $urandom_range(1, 64) * 512;
      x = $urandom_range(0, p - 1);
      y = $urandom_range(0, 8191);
      case (lay)
        0: t = st ? "R7 random" : "R1 random";
        1: t = sw ? "R5 random" : "R2 random";
        2: t = sw ? "R6 random" : "R3 random";
        default: t = sw ? "R6 random" : "R4 random";
      endcase
      drive(t, lay, st, sw, p, x, y);
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    idle(3);
    @(negedge clk);
    check("R8 all results returned", expQ.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule